// File: doc/BRIEF.md
# Return-to-Zero Word Serialiser with Transmit Queue

This block queues 32-bit words for a two-wire return-to-zero serial line and sends them out one at a time. A host loads each word through a 16-bit port in two writes, low half first. A repeater input can also push a complete word straight into the same queue, without the host. The queue holds up to 32 words and shows how full it is on two flag outputs.

When the enable input is high and the queue holds a word, the serialiser takes the oldest word and formats it. Formatting can reverse the low byte into on-wire order, and it can replace bit 32 with generated odd parity. The formatted word is sent least significant bit first. Each bit occupies two equal half periods. The length of a half period comes from a rate select, which is read at the start of each word. After every word the serialiser holds a null gap before it may start the next word. A word that has started always finishes, even if the enable input drops while it is being sent.

Top module: `swtx_top`

## Requirements
- R1: The queue holds DEPTH (32) words. Words leave in the same order in which they entered.
- R2: A host word takes two strobed writes of `wr_data_i`. The first write gives bits 15:0 and the second gives bits 31:16. The word enters the queue on the second write.
- R3: `half_full_o` is high while the queue holds at least DEPTH/2 words. `full_o` is high while it holds DEPTH words. Both flags follow a push at the next clock.
- R4: While `full_o` is high, host writes and repeater pushes are ignored. The stored words are then sent unchanged, and no extra word appears.
- R5: With `parity_en_i` high, wire bit 31 is set so that the 32 transmitted bits contain an odd number of ones. With `parity_en_i` low, the host's bit 31 is sent unchanged.
- R6: With `reorder_en_i` high, wire bits 7:0 are the host bits 7:0 in reverse order (wire bit i = host bit 7-i). With it low, the word is sent as stored. Wire bit 0 is sent first.
- R7: A one drives `line_a_o` high for one half period and a zero drives `line_b_o` high for one half period. Both lines are low in the second half of every bit, and they are never high together. With `rate_lo_i` low, a half period is HALF_HI (5) clocks.
- R8: With `rate_lo_i` high when a word starts, every half period of that word is HALF_LO (40) clocks.
- R9: No word starts while `tx_en_i` is low. If `tx_en_i` drops during a word, that word still completes and no further word starts.
- R10: After the last bit of a word, both lines stay low for at least GAP_BITS (4) bit times before the next word.
- R11: `rep_valid_i` pushes `rep_data_i` as one complete word. A host write in the same cycle is dropped, and it does not advance the half-word sequence.
- R12: After reset both lines are low, both flags are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host half-word write strobe |
| wr_data_i | input | 16 | Host half-word |
| rep_valid_i | input | 1 | Repeater push strobe |
| rep_data_i | input | 32 | Repeater word |
| tx_en_i | input | 1 | Transmit enable |
| parity_en_i | input | 1 | Bit 32 carries generated odd parity |
| reorder_en_i | input | 1 | Reverse low byte into wire order |
| rate_lo_i | input | 1 | Select low speed |
| line_a_o | output | 1 | Line high for a one bit |
| line_b_o | output | 1 | Line high for a zero bit |
| half_full_o | output | 1 | Queue at least half full |
| full_o | output | 1 | Queue full |

## Verification
The queue flags are due one clock after the push edge. The bench samples them on the falling edge that follows the write, with the enable held low so that no pop can interfere. The line outputs depend on the rate and on how long the queue waits, so the bench does not predict their absolute cycle. A falling-edge monitor decodes them instead: it measures each high pulse against the half period of the current rate and counts the low cycles between words against the gap minimum. It rebuilds each 32-bit word and compares it with a queue of expected formatted words. Configuration changes only while the queue is empty and the enable is low, so every expected word is formatted with the settings that the design reads when it starts that word.

// File: rtl/swtx_pkg.sv
package swtx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LABEL_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_GAP} tx_state_e;

  function automatic logic [WORD_W-1:0] format_word(
    input logic [WORD_W-1:0] d,
    input logic par,
    input logic reo
  );
    logic [WORD_W-1:0] w;
    w = d;
    if (reo) begin
      for (int i = 0; i < LABEL_W; i++) w[i] = d[LABEL_W-1-i];
    end
    if (par) w[WORD_W-1] = ~^w[WORD_W-2:0];
    return w;
  endfunction
endpackage

// File: rtl/swtx_fifo.sv
module swtx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/swtx_loader.sv
module swtx_loader
  import swtx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              rep_valid_i,
  input  logic [WORD_W-1:0] rep_data_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o
);
  logic [HALF_W-1:0] lo_q;
  logic              have_lo_q;
  logic              rep_go, host_ok;

  // repeater wins; a colliding host write is dropped
  assign rep_go  = rep_valid_i && !full_i;
  assign host_ok = wr_en_i && !full_i && !rep_valid_i;

  assign push_o      = rep_go || (host_ok && have_lo_q);
  assign push_data_o = rep_go ? rep_data_i : {wr_data_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q      <= '0;
      have_lo_q <= 1'b0;
    end else if (host_ok) begin
      if (have_lo_q) begin
        have_lo_q <= 1'b0;
      end else begin
        lo_q      <= wr_data_i;
        have_lo_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swtx_serializer.sv
module swtx_serializer
  import swtx_pkg::*;
#(
  parameter int HALF_HI  = 5,
  parameter int HALF_LO  = 40,
  parameter int GAP_BITS = 4,
  localparam int HMAX = (HALF_LO > HALF_HI) ? HALF_LO : HALF_HI,
  localparam int CNT_W = $clog2(HMAX) + 1,
  localparam int NHALF = 2 * WORD_W,
  localparam int NGAP = 2 * GAP_BITS,
  localparam int PH_MAX = (NGAP > NHALF) ? NGAP : NHALF,
  localparam int PH_W = $clog2(PH_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              empty_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              parity_en_i,
  input  logic              reorder_en_i,
  input  logic              rate_lo_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              line_a_o,
  output logic              line_b_o
);
  tx_state_e         state_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q, half_len_q;
  logic [PH_W-1:0]   ph_q;
  logic              half_done, drive;

  assign pop_o     = (state_q == ST_IDLE) && tx_en_i && !empty_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign half_done = (cnt_q == half_len_q - 1'b1);
  assign drive     = (state_q == ST_BITS) && !ph_q[0];
  assign line_a_o  = drive && sh_q[0];
  assign line_b_o  = drive && !sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      half_len_q <= CNT_W'(HALF_HI);
      ph_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pop_o) begin
            sh_q       <= format_word(head_i, parity_en_i, reorder_en_i);
            half_len_q <= rate_lo_i ? CNT_W'(HALF_LO) : CNT_W'(HALF_HI);
            cnt_q      <= '0;
            ph_q       <= '0;
            state_q    <= ST_BITS;
          end
        end
        ST_BITS: begin
          if (half_done) begin
            cnt_q <= '0;
            if (ph_q == PH_W'(NHALF - 1)) begin
              ph_q    <= '0;
              state_q <= ST_GAP;
            end else begin
              ph_q <= ph_q + 1'b1;
              if (ph_q[0]) sh_q <= sh_q >> 1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (half_done) begin
            cnt_q <= '0;
            if (ph_q == PH_W'(NGAP - 1)) begin
              ph_q    <= '0;
              state_q <= ST_IDLE;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swtx_top.sv
module swtx_top
  import swtx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HALF_HI  = 5,
  parameter int HALF_LO  = 40,
  parameter int GAP_BITS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        rep_valid_i,
  input  logic [31:0] rep_data_i,
  input  logic        tx_en_i,
  input  logic        parity_en_i,
  input  logic        reorder_en_i,
  input  logic        rate_lo_i,
  output logic        line_a_o,
  output logic        line_b_o,
  output logic        half_full_o,
  output logic        full_o
);
  logic              push, pop, empty, tx_busy;
  logic [WORD_W-1:0] push_data, head;
  logic [CW-1:0]     fill_cnt;

  swtx_loader u_load (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rep_valid_i, .rep_data_i,
    .full_i(full_o), .push_o(push), .push_data_o(push_data)
  );

  swtx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .head_o(head), .count_o(fill_cnt), .empty_o(empty), .full_o(full_o)
  );

  swtx_serializer #(.HALF_HI(HALF_HI), .HALF_LO(HALF_LO), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i, .rst_ni, .tx_en_i, .empty_i(empty), .head_i(head),
    .parity_en_i, .reorder_en_i, .rate_lo_i,
    .pop_o(pop), .busy_o(tx_busy), .line_a_o, .line_b_o
  );

  assign half_full_o = (fill_cnt >= CW'(DEPTH / 2));
endmodule

// File: rtl/swtx_checker.sv
module swtx_checker #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          line_a_i,
  input logic          line_b_i,
  input logic          half_full_i,
  input logic          full_i,
  input logic [CW-1:0] fill_i,
  input logic          busy_i,
  input logic          pop_i
);
  p_fill_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH));

  p_full_has_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> half_full_i);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !pop_i) |=> $stable(fill_i));

  p_lines_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_a_i && line_b_i));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!line_a_i && !line_b_i));

  p_start_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(tx_en_i));
endmodule

bind swtx_top swtx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i),
  .line_a_i(line_a_o), .line_b_i(line_b_o),
  .half_full_i(half_full_o), .full_i(full_o),
  .fill_i(fill_cnt), .busy_i(tx_busy), .pop_i(pop)
);

// File: tb/swtx_top_test.sv
module swtx_top_test;
  localparam int HALF_HI = 5;
  localparam int HALF_LO = 40;
  localparam int GAP_BITS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rep_valid = 1'b0, tx_en = 1'b0;
  logic par = 1'b0, reo = 1'b0, rlo = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] rep_data = '0;
  logic la, lb, hf, ff;

  always #10 clk = ~clk;

  swtx_top #(.DEPTH(32), .HALF_HI(HALF_HI), .HALF_LO(HALF_LO), .GAP_BITS(GAP_BITS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rep_valid_i(rep_valid), .rep_data_i(rep_data), .tx_en_i(tx_en),
    .parity_en_i(par), .reorder_en_i(reo), .rate_lo_i(rlo),
    .line_a_o(la), .line_b_o(lb), .half_full_o(hf), .full_o(ff)
  );

  int n_tests = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [31:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] d, input bit p, input bit r);
    logic [31:0] w;
    int ones;
    w = d;
    if (r) for (int i = 0; i < 8; i++) w[7-i] = d[i];
    if (p) begin
      ones = 0;
      for (int i = 0; i < 31; i++) ones += int'(w[i]);
      w[31] = (ones % 2 == 0);
    end
    return w;
  endfunction

  // line monitor
  int exp_half = HALF_HI, gap_half = HALF_HI;
  int hi_len = 0, low_run = 0, bitcnt = 0, rx_words = 0, pulses = 0;
  bit prev_hi = 0, cur_bit = 0, gap_pend = 0;
  logic [31:0] rx_word = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_len = 0; low_run = 0; bitcnt = 0; prev_hi = 0; gap_pend = 0;
    end else if (la || lb) begin
      if (!prev_hi) begin
        if (gap_pend) begin
          chk(low_run >= 9 * gap_half, "R10", low_run, 9 * gap_half);
          gap_pend = 0;
        end
        hi_len = 1; cur_bit = la; pulses++;
      end else hi_len++;
      low_run = 0;
      prev_hi = 1;
    end else begin
      if (prev_hi) begin
        chk(hi_len == exp_half, (exp_half == HALF_LO) ? "R8" : "R7", hi_len, exp_half);
        rx_word[bitcnt] = cur_bit;
        bitcnt++;
        if (bitcnt == 32) begin
          if (exp_q.size() == 0) chk(0, cur_tag, rx_word, 'x);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(rx_word == e, cur_tag, rx_word, e);
          end
          rx_words++; bitcnt = 0; gap_pend = 1; low_run = 0; gap_half = exp_half;
        end
      end
      low_run++;
      prev_hi = 0;
    end
  end

  task automatic host_word(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d[15:0];
    @(negedge clk); wr_data = d[31:16];
    @(negedge clk); wr_en = 0;
    exp_q.push_back(expect_word(d, par, reo));
  endtask

  task automatic rep_word(input logic [31:0] d);
    @(negedge clk); rep_valid = 1; rep_data = d;
    @(negedge clk); rep_valid = 0;
    exp_q.push_back(expect_word(d, par, reo));
  endtask

  task automatic config_set(input bit p, input bit r, input bit lo);
    par = p; reo = r; rlo = lo; exp_half = lo ? HALF_LO : HALF_HI;
  endtask

  task automatic drain(input string tag);
    int target, t;
    target = rx_words + exp_q.size();
    @(negedge clk); tx_en = 1;
    t = 0;
    while (rx_words < target && t < 60000) begin @(negedge clk); t++; end
    tx_en = 0;
    chk(rx_words == target, tag, rx_words, target);
    repeat (10 * HALF_LO) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0, p0;
    logic [31:0] d;
    void'($urandom(32'h1c3d5e7f));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!la && !lb, "R12", {la, lb}, 0);
    chk(!hf && !ff, "R12", {hf, ff}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 halves / R1 order
    cur_tag = "R2"; config_set(0, 0, 0);
    host_word(32'h1234_ABCD); host_word(32'hFFFF_0000); host_word(32'h8000_0001);
    drain("R2");

    // R5 parity
    cur_tag = "R5"; config_set(1, 0, 0);
    host_word(32'h0000_0000); host_word(32'hFFFF_FFFF); host_word(32'h7000_0003);
    drain("R5");

    // R6 low-byte reversal
    cur_tag = "R6"; config_set(0, 1, 0);
    host_word(32'h0000_0001); host_word(32'hA5A5_00F0);
    drain("R6");

    // R8 low speed
    cur_tag = "R8"; config_set(0, 0, 1);
    host_word(32'hC0DE_5A5A); rep_word(32'h0F0F_1234);
    drain("R8");

    // R11 repeater vs host collision
    cur_tag = "R11"; config_set(0, 0, 0);
    @(negedge clk); wr_en = 1; wr_data = 16'h1111;
    @(negedge clk); wr_data = 16'h2222; rep_valid = 1; rep_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_en = 0; rep_valid = 0;
    exp_q.push_back(32'hDEAD_BEEF);
    @(negedge clk); wr_en = 1; wr_data = 16'h3333;
    @(negedge clk); wr_en = 0;
    exp_q.push_back(32'h3333_1111);
    drain("R11");

    // R9 enable gating and completion after drop
    cur_tag = "R9";
    host_word(32'h5555_AAAA); host_word(32'h0123_4567);
    p0 = pulses; w0 = rx_words;
    repeat (300) @(negedge clk);
    chk(pulses == p0, "R9", pulses, p0);
    @(negedge clk); tx_en = 1;
    while (pulses == p0) @(negedge clk);
    tx_en = 0;
    repeat (3000) @(negedge clk);
    chk(rx_words == w0 + 1, "R9", rx_words, w0 + 1);
    chk(bitcnt == 0, "R9", bitcnt, 0);
    drain("R9");

    // R3 flags and R4 overflow
    cur_tag = "R4";
    for (int i = 0; i < 32; i++) begin
      host_word(32'hF000_0000 + i * 32'h0101_0011);
      if (i == 14) chk(!hf, "R3", hf, 0);
      if (i == 15) chk(hf, "R3", hf, 1);
      if (i == 30) chk(!ff, "R3", ff, 0);
      if (i == 31) chk(ff && hf, "R3", {ff, hf}, 2'b11);
    end
    @(negedge clk); wr_en = 1; wr_data = 16'h9999;
    @(negedge clk); wr_data = 16'h8888;
    @(negedge clk); wr_en = 0; rep_valid = 1; rep_data = 32'h7777_7777;
    @(negedge clk); rep_valid = 0;
    chk(ff, "R4", ff, 1);
    drain("R4");
    chk(!ff && !hf, "R3", {ff, hf}, 0);

    // random rounds, R1
    cur_tag = "R1";
    for (int r = 0; r < 10; r++) begin
      int n;
      config_set($urandom % 2, $urandom % 2, ($urandom % 4) == 0);
      n = 1 + $urandom % 4;
      for (int k = 0; k < n; k++) begin
        d = $urandom;
        if ($urandom % 2) host_word(d); else rep_word(d);
      end
      drain("R1");
    end

    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);
    chk(bitcnt == 0, "R7", bitcnt, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule